// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block moves a set of registers between a register file and word-addressed memory, one word per transfer. The caller gives it a base address, a 16-bit selection mask, a direction (load or store) and a flag that asks for the base to be updated. The block then walks the selected registers one at a time. For each one it raises a request on a simple memory port and waits for that access to be answered. On a store it reads the register file and places the value on the memory write data. On a load it writes the returned memory word into the register file.

The two directions walk memory in opposite ways. A store places the lowest selected register at the base address and moves upward one word per register. A load starts one word below the base and moves downward, taking the highest selected register first. So a store leaves the pointer above the block and a load leaves it below. When the caller asks for it, that end address is offered back as the new base in the cycle where the block reports completion.

Top module: `lsm_seq`

## Requirements
- R1: A store transfers the selected registers in ascending index order (mask bit i selects register i). The k-th transfer (k counting from 0) writes the current content of its register to address base + 4·k with `mem_we` high.
- R2: A load transfers the selected registers in descending index order. The k-th transfer reads address base − 4·(k+1) with `mem_we` low.
- R3: In the completion cycle, `base_out` equals base + 4·n after a store and base − 4·n after a load, where n is the number of set mask bits. Arithmetic wraps modulo 2^32.
- R4: `base_we` is high only in the completion cycle, and only when the write-back flag was set at start. Otherwise it stays low.
- R5: An all-zero mask issues no memory request. Completion follows in the cycle after start, and `base_out` equals the base.
- R6: A request whose `mem_ready` is low is held: `mem_req`, `mem_addr`, `mem_we` and the register index stay unchanged until the cycle where `mem_ready` is high.
- R7: `busy` rises in the cycle after an accepted start, and the first request appears in that same cycle. `done` is high for exactly one cycle, which is the cycle after the last accepted response. `busy` is low again in the cycle after `done`.
- R8: `start` is ignored while `busy` is high. The transfer order, the addresses, the data and the final base are unaffected by any input seen during that time.
- R9: On a load, the register-file write happens in the same cycle as the accepted response. It uses the register index of that transfer and the returned `mem_rdata`. `rf_we` is low in every other cycle.
- R10: After reset, `busy`, `done`, `mem_req`, `rf_we` and `base_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block transfer when idle |
| is_load | input | 1 | 1 selects load from memory, 0 selects store to memory |
| wb_en | input | 1 | Offer the end address as the new base on completion |
| base_in | input | 32 | Base address |
| mask_in | input | 16 | Register selection, bit i selects register i |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data for a store |
| mem_ready | input | 1 | Access answered in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data for rf_raddr, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| base_we | output | 1 | End address valid for the base register |
| base_out | output | 32 | End address |
| busy | output | 1 | Transfer in progress, including the completion cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in one cycle. The first is the completion cycle with its base write-back. The second is a fresh start request, which must be refused because the block is still busy. The bench drives random start pulses with random masks, bases and directions in every busy cycle, including the one that shows `done`. It then judges that the refused request left the finished transfer's base value intact and that no extra request follows. The same overlap occurs on loads, where the answered memory access and the register-file write share one cycle. That is checked beat by beat against addresses, indices and data the bench derives from the mask.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MOVE = 2'd1,
      ST_FIN  = 2'd2
   } lsm_state_e;

endpackage

// File: rtl/lsm_pick.sv
// Chooses the next register from the remaining selection mask:
// lowest set bit for ascending walks, highest for descending walks.
module lsm_pick #(
   parameter int NREG = 16,
   parameter int IW   = 4
) (
   input  logic [NREG-1:0] mask,
   input  logic            hi_first,
   output logic [IW-1:0]   idx
);

   if (NREG < 2) begin : g_bad_nreg
      $error("lsm_pick: NREG must be at least 2");
   end
   if ((1 << IW) < NREG) begin : g_bad_iw
      $error("lsm_pick: IW too narrow for NREG");
   end

   logic [IW-1:0] lo_idx;
   logic [IW-1:0] hi_idx;

   always_comb begin
      lo_idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (mask[i]) lo_idx = IW'(i);
      end
   end

   always_comb begin
      hi_idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (mask[i]) hi_idx = IW'(i);
      end
   end

   assign idx = hi_first ? hi_idx : lo_idx;

endmodule

// File: rtl/lsm_addr.sv
// Address pointer: holds the running block pointer. Ascending walks
// access at the pointer, descending walks one word below it.
module lsm_addr #(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          down,
   input  logic          advance,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] ptr,
   output logic [AW-1:0] acc
);

   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   if (STEP < 1 || (STEP & (STEP - 1)) != 0) begin : g_bad_step
      $error("lsm_addr: STEP must be a power of two");
   end

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load) begin
         ptr_q <= base;
      end else if (advance) begin
         ptr_q <= down ? (ptr_q - STEP_V) : (ptr_q + STEP_V);
      end
   end

   assign ptr = ptr_q;
   assign acc = down ? (ptr_q - STEP_V) : ptr_q;

   // R1 R2
   step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && !down) |=> (ptr == $past(ptr) + STEP_V));

endmodule

// File: rtl/lsm_ctrl.sv
// Control sequencer: accepts a request when idle, steps through the
// selection mask on each answered access, then signals completion.
module lsm_ctrl
   import lsm_pkg::*;
#(
   parameter int NREG = 16,
   parameter int IW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            is_load_in,
   input  logic            wb_in,
   input  logic [NREG-1:0] mask_in,
   input  logic            mem_ready,
   input  logic [IW-1:0]   pick_idx,
   output logic [NREG-1:0] mask_q,
   output logic            ld_q,
   output logic            wb_q,
   output logic            in_move,
   output logic            in_fin,
   output logic            ptr_load,
   output logic            advance
);

   lsm_state_e      state_q;
   logic [NREG-1:0] clr;
   logic [NREG-1:0] rest;

   for (genvar g = 0; g < NREG; g++) begin : g_clr
      assign clr[g] = (pick_idx == IW'(g));
   end

   assign rest     = mask_q & ~clr;
   assign in_move  = (state_q == ST_MOVE);
   assign in_fin   = (state_q == ST_FIN);
   assign ptr_load = (state_q == ST_IDLE) && start;
   assign advance  = in_move && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
         ld_q    <= 1'b0;
         wb_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mask_q  <= mask_in;
                  ld_q    <= is_load_in;
                  wb_q    <= wb_in;
                  state_q <= (|mask_in) ? ST_MOVE : ST_FIN;
               end
            end
            ST_MOVE: begin
               if (mem_ready) begin
                  mask_q <= rest;
                  if (rest == '0) state_q <= ST_FIN;
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1 R2
   pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_move |-> mask_q[pick_idx]);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_move && !mem_ready) |=> (in_move && $stable(mask_q)));

   // R5
   empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start && mask_in == '0) |=> in_fin);

   // R7
   fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_fin |=> !in_fin && !in_move);

   // R8
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_move && start && !mem_ready) |=> $stable(ld_q) && $stable(wb_q));

endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int NREG = 16,
   parameter int WORD_BYTES = 4,
   localparam int IW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            is_load,
   input  logic            wb_en,
   input  logic [AW-1:0]   base_in,
   input  logic [NREG-1:0] mask_in,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ready,
   input  logic [DW-1:0]   mem_rdata,
   output logic [IW-1:0]   rf_raddr,
   input  logic [DW-1:0]   rf_rdata,
   output logic            rf_we,
   output logic [IW-1:0]   rf_waddr,
   output logic [DW-1:0]   rf_wdata,
   output logic            base_we,
   output logic [AW-1:0]   base_out,
   output logic            busy,
   output logic            done
);

   if (AW < 8) begin : g_bad_aw
      $error("lsm_seq: AW must be at least 8");
   end
   if (DW < 8) begin : g_bad_dw
      $error("lsm_seq: DW must be at least 8");
   end

   logic [NREG-1:0] mask_q;
   logic            ld_q;
   logic            wb_q;
   logic            in_move;
   logic            in_fin;
   logic            ptr_load;
   logic            advance;
   logic [IW-1:0]   pick_idx;
   logic [AW-1:0]   ptr;
   logic [AW-1:0]   acc;

   lsm_pick #(.NREG(NREG), .IW(IW)) u_pick (
      .mask     (mask_q),
      .hi_first (ld_q),
      .idx      (pick_idx)
   );

   lsm_ctrl #(.NREG(NREG), .IW(IW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .is_load_in (is_load),
      .wb_in      (wb_en),
      .mask_in    (mask_in),
      .mem_ready  (mem_ready),
      .pick_idx   (pick_idx),
      .mask_q     (mask_q),
      .ld_q       (ld_q),
      .wb_q       (wb_q),
      .in_move    (in_move),
      .in_fin     (in_fin),
      .ptr_load   (ptr_load),
      .advance    (advance)
   );

   lsm_addr #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ptr_load),
      .down    (ld_q),
      .advance (advance),
      .base    (base_in),
      .ptr     (ptr),
      .acc     (acc)
   );

   assign mem_req   = in_move;
   assign mem_we    = in_move && !ld_q;
   assign mem_addr  = acc;
   assign mem_wdata = rf_rdata;
   assign rf_raddr  = pick_idx;
   assign rf_we     = in_move && ld_q && mem_ready;
   assign rf_waddr  = pick_idx;
   assign rf_wdata  = mem_rdata;
   assign busy      = in_move || in_fin;
   assign done      = in_fin;
   assign base_we   = in_fin && wb_q;
   assign base_out  = ptr;

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R9
   rf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (mem_req && mem_ready && !mem_we));

   // R4
   base_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |-> done);

   // R7
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done) |-> busy);

endmodule

// File: tb/sim_lsm_seq.sv
`timescale 1ns/1ps
module sim_lsm_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_load = 1'b0;
   logic        wb_en = 1'b0;
   logic [31:0] base_in = '0;
   logic [15:0] mask_in = '0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata;
   logic [3:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        rf_we;
   logic [3:0]  rf_waddr;
   logic [31:0] rf_wdata;
   logic        base_we;
   logic [31:0] base_out;
   logic        busy;
   logic        done;

   logic [31:0] rf [16];
   logic [31:0] snap [16];
   int          exp_reg [16];
   logic [31:0] exp_addr [16];
   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;

   always #10 clk = ~clk;

   lsm_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load), .wb_en(wb_en),
      .base_in(base_in), .mask_in(mask_in), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .base_we(base_we), .base_out(base_out), .busy(busy), .done(done)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   assign mem_rdata = mem_word(mem_addr);
   assign rf_rdata  = rf[rf_raddr];

   always @(posedge clk) begin
      if (rf_we) rf[rf_waddr] <= rf_wdata;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   // one cycle: drive at the falling edge, sample 1 ns later
   task automatic tick(input bit junk);
      @(negedge clk);
      mem_ready = ($urandom % 4) != 0;
      if (busy && junk) begin
         start   = $urandom % 2;
         mask_in = 16'($urandom);
         base_in = $urandom;
         is_load = $urandom % 2;
         wb_en   = $urandom % 2;
      end else begin
         start = 1'b0;
      end
      #1;
      cyc++;
   endtask

   task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                         input bit ld, input bit wb);
      int n;
      int beat;
      int start_cyc;
      int last_cyc;
      bit seen_req;
      bit fin;
      bit stall;
      logic [31:0] stall_a;
      logic [31:0] exp_end;
      n = 0;
      for (int i = 0; i < 16; i++) snap[i] = rf[i];
      if (!ld) begin
         for (int i = 0; i < 16; i++) if (mask[i]) begin
            exp_reg[n] = i; exp_addr[n] = base + 32'(4 * n); n++;
         end
         exp_end = base + 32'(4 * n);
      end else begin
         for (int i = 15; i >= 0; i--) if (mask[i]) begin
            exp_reg[n] = i; exp_addr[n] = base - 32'(4 * (n + 1)); n++;
         end
         exp_end = base - 32'(4 * n);
      end
      @(negedge clk);
      mem_ready = 1'b0;
      start = 1'b1; base_in = base; mask_in = mask; is_load = ld; wb_en = wb;
      #1; cyc++;
      start_cyc = cyc;
      beat = 0; last_cyc = cyc; seen_req = 0; fin = 0; stall = 0; stall_a = '0;
      for (int t = 0; t < 300 && !fin; t++) begin
         tick(1'b1);
         if (mem_req && !seen_req) begin
            seen_req = 1;
            chk(cyc == start_cyc + 1, "R7", "first request cycle", 32'(cyc), 32'(start_cyc + 1));
         end
         if (mem_req && stall)
            chk(mem_addr == stall_a, "R6", "address held during stall", mem_addr, stall_a);
         stall = mem_req && !mem_ready;
         stall_a = mem_addr;
         if (mem_req && mem_ready) begin
            if (beat >= n) begin
               chk(1'b0, ld ? "R2" : "R1", "extra transfer", 32'(beat), 32'(n));
            end else if (!ld) begin
               chk(mem_we && mem_addr == exp_addr[beat], "R1", "store address",
                   mem_addr, exp_addr[beat]);
               chk(mem_wdata == snap[exp_reg[beat]], "R1", "store data",
                   mem_wdata, snap[exp_reg[beat]]);
               chk(!rf_we, "R9", "no rf write on store", 32'(rf_we), 32'd0);
            end else begin
               chk(!mem_we && mem_addr == exp_addr[beat], "R2", "load address",
                   mem_addr, exp_addr[beat]);
               chk(rf_we && rf_waddr == 4'(exp_reg[beat]), "R9", "load rf index",
                   {27'd0, rf_we, rf_waddr}, {28'd1, 4'(exp_reg[beat])});
               chk(rf_wdata == mem_word(exp_addr[beat]), "R9", "load rf data",
                   rf_wdata, mem_word(exp_addr[beat]));
            end
            beat++;
            last_cyc = cyc;
         end else if (rf_we) begin
            chk(1'b0, "R9", "rf write outside response", 32'(rf_we), 32'd0);
         end
         if (done) begin
            fin = 1;
            chk(beat == n, "R7", "transfer count at done", 32'(beat), 32'(n));
            if (n == 0) begin
               chk(!seen_req, "R5", "no request for empty mask", 32'(seen_req), 32'd0);
               chk(cyc == start_cyc + 1, "R5", "empty done cycle", 32'(cyc), 32'(start_cyc + 1));
            end else begin
               chk(cyc == last_cyc + 1, "R7", "done after last response", 32'(cyc), 32'(last_cyc + 1));
            end
            chk(busy, "R7", "busy during done", 32'(busy), 32'd1);
            chk(base_we == wb, "R4", "base write enable", 32'(base_we), 32'(wb));
            chk(base_out == exp_end, "R3", "end address", base_out, exp_end);
         end else begin
            if (base_we) chk(1'b0, "R4", "base write outside done", 32'(base_we), 32'd0);
         end
      end
      if (!fin) chk(1'b0, "R7", "operation timeout", 32'(beat), 32'(n));
      tick(1'b0);
      chk(!busy && !done && !mem_req, "R8", "idle after done despite start",
          {29'd0, busy, done, mem_req}, 32'd0);
   endtask

   initial begin
      #(20ns * 200000);
      chk(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i * 32'h0101_0101);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R10 reset state
      chk(!busy && !done && !mem_req && !rf_we && !base_we, "R10", "reset outputs",
          {27'd0, busy, done, mem_req, rf_we, base_we}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!busy && !done && !mem_req, "R10", "idle after reset release",
          {29'd0, busy, done, mem_req}, 32'd0);

      // directed corners
      run_op(32'h0000_1000, 16'h0000, 1'b0, 1'b1);   // R5 empty store
      run_op(32'h0000_2000, 16'h0000, 1'b1, 1'b1);   // R5 empty load
      run_op(32'h0000_3000, 16'hFFFF, 1'b0, 1'b1);   // R1 full store
      run_op(32'h0000_4000, 16'hFFFF, 1'b1, 1'b0);   // R2 full load, R4 no wb
      run_op(32'h0000_0500, 16'h0001, 1'b0, 1'b1);   // R1 lowest only
      run_op(32'h0000_0600, 16'h8000, 1'b1, 1'b1);   // R2 highest only
      run_op(32'h0000_0004, 16'h8421, 1'b1, 1'b1);   // R3 wrap below zero
      run_op(32'hFFFF_FFF8, 16'h0C03, 1'b0, 1'b1);   // R3 wrap above top
      run_op(32'h0000_7000, 16'h00F0, 1'b0, 1'b0);   // R4 store no wb

      // random mix
      for (int k = 0; k < 60; k++) begin
         logic [15:0] m;
         case ($urandom % 6)
            0:       m = 16'h0000;
            1:       m = 16'hFFFF;
            default: m = 16'($urandom);
         endcase
         run_op($urandom & 32'hFFFF_FFFC, m, 1'($urandom % 2), 1'($urandom % 2));
      end
      finish_run();
   end

endmodule